// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side status logic of one parallel NOR flash bank. It receives program, erase, suspend, resume and abort events that a command decoder has already recognised, along with the target address, the data byte and a mask of the selected sectors. It also takes one protection flag per sector. A behavioural busy timer stands in for the cell array, so the block decides how long each operation lasts. For every read it either forwards the array data presented at its input or replaces the byte with a status word. The status bits report progress, toggle activity, a timeout and the start of an erase.

A host polls the bank by reading repeatedly. The most significant bit shows the complement of the programmed bit, or a zero while an erase runs. Bit 6 alternates on every status read. Bit 5 flags an operation that overran its time limit. Bit 3 shows whether the erase has left its acceptance window. Bit 2 identifies the sectors that are being erased. While a program or an erase is suspended, reads from sectors that are not affected return normal data. A program into a protected sector, or an erase whose selected sectors are all protected, reports busy for a short fixed period and then leaves the bank in read mode.

Top module: `flash_status_gen`

## Requirements
- R1: While a program runs, a status read returns bit 7 equal to the inverse of bit 7 of the programmed byte, with bits 5, 4, 3, 1 and 0 at 0 and bit 2 at 1.
- R2: A read is registered: `rd_data` takes its new value at the clock edge that samples `rd_en`, and holds that value in cycles without a read. In read mode the new value is `arr_data`, which includes every read made after an operation has completed.
- R3: In every busy state except erase suspend, bit 6 of each status read is the inverse of bit 6 of the previous status read.
- R4: During an erase, bit 7 reads 0. Bit 3 reads 0 for the first ACCEPT_CYC cycles after the erase event and 1 once the erase itself has started. The erase phase lasts ERASE_CYC_PER_SECT cycles for each selected sector that is not protected. The sector of an address is its upper log2(NUM_SECT) bits.
- R5: While an erase is in its window, running or failed, each status read from a sector being erased inverts bit 2. A status read from any other sector leaves bit 2 unchanged.
- R6: A suspend event during the running erase phase enters erase suspend. In that state a read from a sector being erased returns bits 7 and 6 at 1, bits 5 and 3 at 0, and bit 2 inverted on every such read. Reads from all other sectors return `arr_data`.
- R7: During erase suspend, a program to a sector that is not being erased runs with the R1 status for every address and then returns to erase suspend. A program to a sector that is being erased is ignored.
- R8: A suspend event during a program enters program suspend, in which every read returns `arr_data`. A resume event restores the program status and the remaining busy time.
- R9: A program to a protected sector shows program status for PROG_PROT_CYC cycles instead of PROG_CYC. An erase whose selected sectors are all protected shows erase status with bit 3 at 0 for ERASE_PROT_CYC cycles. After either period the bank is back in read mode.
- R10: If the erase phase would last longer than ERASE_TMO_CYC cycles, it stops after that many cycles and status reads return bit 5 at 1, bit 7 at 0 and bit 6 toggling. This lasts until an abort event returns the bank to read mode.
- R11: Program and erase events that arrive while the bank is busy are ignored, apart from the case in R7. An abort event has no effect unless a timeout is pending.
- R12: After reset `rd_data` is 0 and the first status read returns bit 6 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_go | input | 1 | Decoded program event (final write strobe) |
| prog_addr | input | ADDR_W | Program target address |
| prog_data | input | 8 | Program data byte |
| erase_go | input | 1 | Decoded erase event (final write strobe) |
| erase_sel | input | NUM_SECT | Sectors selected for erase |
| susp_go | input | 1 | Suspend event |
| resume_go | input | 1 | Resume event |
| abort_go | input | 1 | Abort event, clears a timeout |
| sect_prot | input | NUM_SECT | Per-sector protection flags |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | 8 | Array data for the read address |
| rd_data | output | 8 | Read result, array data or status |

## Verification
The bench builds the block with eight sectors and an 8-bit address, and protects the top sector. The busy periods are set to 12 cycles for a program, 5 for a protected program, 6 for the acceptance window, 20 per erased sector, 30 for a fully protected erase and 50 for the erase limit. These short periods let a single read land clearly before or after each period ends. Erasing three sectors therefore overruns the limit, while erasing two does not, so the timeout path and the normal erase completion can both be observed in short runs.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  localparam int DQ_W = 8;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_PROG   = 4'd1,
    S_PSUSP  = 4'd2,
    S_EWIN   = 4'd3,
    S_ERASE  = 4'd4,
    S_ESUSP  = 4'd5,
    S_ESPROG = 4'd6,
    S_PERASE = 4'd7,
    S_FAIL   = 4'd8
  } fs_mode_t;

  // status word while a program is busy
  function automatic logic [DQ_W-1:0] prog_word(input logic d7, input logic t6);
    return {~d7, t6, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00};
  endfunction

  // status word while an erase is in window, running, failed or guarded
  function automatic logic [DQ_W-1:0] erase_word(input logic t6, input logic tmo,
                                                 input logic started, input logic t2);
    return {1'b0, t6, tmo, 1'b0, started, t2, 2'b00};
  endfunction

  // status word for a read of a suspended erase sector
  function automatic logic [DQ_W-1:0] esusp_word(input logic t2);
    return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, t2, 2'b00};
  endfunction

endpackage

// File: rtl/fst_ctrl.sv
module fst_ctrl
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECT           = 8,
  parameter int SECT_W             = 3,
  parameter int CNT_W              = 24,
  parameter int PROG_CYC           = 300,
  parameter int PROG_PROT_CYC      = 50,
  parameter int ACCEPT_CYC         = 2500,
  parameter int ERASE_CYC_PER_SECT = 50000,
  parameter int ERASE_PROT_CYC     = 20000,
  parameter int ERASE_TMO_CYC      = 400000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_go,
  input  logic [SECT_W-1:0]   prog_sect,
  input  logic                prog_msb,
  input  logic                erase_go,
  input  logic [NUM_SECT-1:0] erase_sel,
  input  logic                susp_go,
  input  logic                resume_go,
  input  logic                abort_go,
  input  logic [NUM_SECT-1:0] sect_prot,
  output fs_mode_t            mode,
  output logic [NUM_SECT-1:0] esel,
  output logic                pd7
);

  localparam int NW = $clog2(NUM_SECT + 1);

  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    ecnt;
  logic [CNT_W-1:0]    el;
  logic [NUM_SECT-1:0] eff;
  logic [NW-1:0]       n_eff;
  logic                prog_prot;
  logic                prog_in_erase;
  logic [CNT_W-1:0]    prog_load;
  logic [CNT_W-1:0]    erase_load;
  logic                ev_tmo;

  assign eff           = erase_sel & ~sect_prot;
  assign prog_prot     = sect_prot[prog_sect];
  assign prog_in_erase = esel[prog_sect];
  assign prog_load     = prog_prot ? CNT_W'(PROG_PROT_CYC - 1) : CNT_W'(PROG_CYC - 1);

  always_comb begin
    n_eff = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (eff[i]) n_eff = n_eff + NW'(1);
    end
  end

  assign erase_load = CNT_W'(ERASE_CYC_PER_SECT) * CNT_W'(n_eff) - CNT_W'(1);

  // erase phase reaches its limit with work still left
  assign ev_tmo = (el == CNT_W'(ERASE_TMO_CYC - 1)) && (ecnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= S_IDLE;
      cnt  <= '0;
      ecnt <= '0;
      el   <= '0;
      esel <= '0;
      pd7  <= 1'b0;
    end else begin
      unique case (mode)
        S_IDLE: begin
          if (prog_go) begin
            mode <= S_PROG;
            cnt  <= prog_load;
            pd7  <= prog_msb;
          end else if (erase_go) begin
            esel <= eff;
            el   <= '0;
            if (eff == '0) begin
              mode <= S_PERASE;
              cnt  <= CNT_W'(ERASE_PROT_CYC - 1);
            end else begin
              mode <= S_EWIN;
              cnt  <= CNT_W'(ACCEPT_CYC - 1);
              ecnt <= erase_load;
            end
          end
        end
        S_PROG: begin
          if (susp_go)          mode <= S_PSUSP;
          else if (cnt == '0)   mode <= S_IDLE;
          else                  cnt  <= cnt - CNT_W'(1);
        end
        S_PSUSP: begin
          if (resume_go) mode <= S_PROG;
        end
        S_EWIN: begin
          if (cnt == '0) mode <= S_ERASE;
          else           cnt  <= cnt - CNT_W'(1);
        end
        S_ERASE: begin
          if (susp_go) begin
            mode <= S_ESUSP;
          end else if (ev_tmo) begin
            mode <= S_FAIL;
          end else if (ecnt == '0) begin
            mode <= S_IDLE;
            esel <= '0;
          end else begin
            ecnt <= ecnt - CNT_W'(1);
            el   <= el + CNT_W'(1);
          end
        end
        S_ESUSP: begin
          if (resume_go) begin
            mode <= S_ERASE;
          end else if (prog_go && !prog_in_erase) begin
            mode <= S_ESPROG;
            cnt  <= prog_load;
            pd7  <= prog_msb;
          end
        end
        S_ESPROG: begin
          if (cnt == '0) mode <= S_ESUSP;
          else           cnt  <= cnt - CNT_W'(1);
        end
        S_PERASE: begin
          if (cnt == '0) mode <= S_IDLE;
          else           cnt  <= cnt - CNT_W'(1);
        end
        S_FAIL: begin
          if (abort_go) begin
            mode <= S_IDLE;
            esel <= '0;
          end
        end
        default: mode <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fst_toggle.sv
module fst_toggle #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] adv,
  output logic [LANES-1:0] q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)      q[g] <= 1'b0;
      else if (adv[g]) q[g] <= ~q[g];
    end
  end

endmodule

// File: rtl/fst_rdmux.sv
module fst_rdmux
  import flash_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  fs_mode_t        mode,
  input  logic            hit,
  input  logic            pd7,
  input  logic            tog6,
  input  logic            tog2,
  input  logic [DQ_W-1:0] arr_data,
  output logic [DQ_W-1:0] rd_data,
  output logic            adv6,
  output logic            adv2
);

  logic [DQ_W-1:0] word;

  always_comb begin
    word = arr_data;
    adv6 = 1'b0;
    adv2 = 1'b0;
    unique case (mode)
      S_PROG, S_ESPROG: begin
        word = prog_word(pd7, tog6);
        adv6 = rd_en;
      end
      S_EWIN: begin
        word = erase_word(tog6, 1'b0, 1'b0, tog2);
        adv6 = rd_en;
        adv2 = rd_en & hit;
      end
      S_ERASE: begin
        word = erase_word(tog6, 1'b0, 1'b1, tog2);
        adv6 = rd_en;
        adv2 = rd_en & hit;
      end
      S_FAIL: begin
        word = erase_word(tog6, 1'b1, 1'b1, tog2);
        adv6 = rd_en;
        adv2 = rd_en & hit;
      end
      S_PERASE: begin
        word = erase_word(tog6, 1'b0, 1'b0, tog2);
        adv6 = rd_en;
      end
      S_ESUSP: begin
        if (hit) begin
          word = esusp_word(tog2);
          adv2 = rd_en;
        end
      end
      default: word = arr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECT           = 8,
  parameter int ADDR_W             = 20,
  parameter int CNT_W              = 24,
  parameter int PROG_CYC           = 300,
  parameter int PROG_PROT_CYC      = 50,
  parameter int ACCEPT_CYC         = 2500,
  parameter int ERASE_CYC_PER_SECT = 50000,
  parameter int ERASE_PROT_CYC     = 20000,
  parameter int ERASE_TMO_CYC      = 400000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_go,
  input  logic [ADDR_W-1:0]   prog_addr,
  input  logic [7:0]          prog_data,
  input  logic                erase_go,
  input  logic [NUM_SECT-1:0] erase_sel,
  input  logic                susp_go,
  input  logic                resume_go,
  input  logic                abort_go,
  input  logic [NUM_SECT-1:0] sect_prot,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [7:0]          arr_data,
  output logic [7:0]          rd_data
);

  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int OFF_W  = ADDR_W - SECT_W;

  fs_mode_t            mode;
  logic [NUM_SECT-1:0] esel;
  logic                pd7;
  logic [SECT_W-1:0]   prog_sect;
  logic [SECT_W-1:0]   rd_sect;
  logic                prog_msb;
  logic [NUM_SECT-1:0] rd_onehot;
  logic                rd_hit;
  logic [1:0]          adv;
  logic [1:0]          tog;

  assign prog_sect = SECT_W'(prog_addr >> OFF_W);
  assign rd_sect   = SECT_W'(rd_addr >> OFF_W);
  assign prog_msb  = (prog_data & 8'h80) != 8'h00;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_dec
    assign rd_onehot[g] = (rd_sect == SECT_W'(g));
  end

  assign rd_hit = |(rd_onehot & esel);

  fst_ctrl #(
    .NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .PROG_PROT_CYC(PROG_PROT_CYC),
    .ACCEPT_CYC(ACCEPT_CYC), .ERASE_CYC_PER_SECT(ERASE_CYC_PER_SECT),
    .ERASE_PROT_CYC(ERASE_PROT_CYC), .ERASE_TMO_CYC(ERASE_TMO_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .prog_go(prog_go), .prog_sect(prog_sect), .prog_msb(prog_msb),
    .erase_go(erase_go), .erase_sel(erase_sel),
    .susp_go(susp_go), .resume_go(resume_go), .abort_go(abort_go),
    .sect_prot(sect_prot),
    .mode(mode), .esel(esel), .pd7(pd7)
  );

  fst_toggle #(.LANES(2)) u_tog (
    .clk(clk), .rst_n(rst_n), .adv(adv), .q(tog)
  );

  fst_rdmux u_mux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mode(mode), .hit(rd_hit),
    .pd7(pd7), .tog6(tog[1]), .tog2(tog[0]), .arr_data(arr_data),
    .rd_data(rd_data), .adv6(adv[1]), .adv2(adv[0])
  );

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
  import flash_stat_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic [7:0] arr_data,
  input logic       abort_go,
  input fs_mode_t   mode,
  input logic       hit
);

  // R2
  no_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == S_IDLE) |=> rd_data == $past(arr_data));

  // R3
  dq6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == S_PROG && $past(rd_en && mode == S_PROG))
      |=> rd_data[6] != $past(rd_data[6]));

  // R4
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == S_EWIN) |=> (!rd_data[3] && !rd_data[7]));

  // R6
  esusp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == S_ESUSP && hit) |=> (rd_data[7:5] == 3'b110 && !rd_data[3]));

  // R6
  esusp_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == S_ESUSP && !hit) |=> rd_data == $past(arr_data));

  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_FAIL && !abort_go) |=> mode == S_FAIL);

  // R10
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == S_FAIL) |=> (rd_data[5] && !rd_data[7]));

endmodule

bind flash_status_gen flash_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
  .arr_data(arr_data), .abort_go(abort_go), .mode(mode), .hit(rd_hit)
);

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/1ps
module sim_flash_status_gen;

  localparam int NS = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_go, erase_go, susp_go, resume_go, abort_go, rd_en;
  logic [AW-1:0] prog_addr, rd_addr;
  logic [7:0]    prog_data, arr_data, rd_data;
  logic [NS-1:0] erase_sel, sect_prot;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  assign arr_data = rd_addr ^ 8'h5A;

  flash_status_gen #(
    .NUM_SECT(NS), .ADDR_W(AW), .CNT_W(16),
    .PROG_CYC(12), .PROG_PROT_CYC(5), .ACCEPT_CYC(6),
    .ERASE_CYC_PER_SECT(20), .ERASE_PROT_CYC(30), .ERASE_TMO_CYC(50)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_go(erase_go), .erase_sel(erase_sel),
    .susp_go(susp_go), .resume_go(resume_go), .abort_go(abort_go),
    .sect_prot(sect_prot), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  // program vectors: [15:8] address, [7:0] data (top sector avoided)
  localparam logic [15:0] PVEC [6] = '{16'h00_80, 16'h21_7F, 16'h45_FF,
                                       16'hC3_00, 16'h6A_A5, 16'hA0_5A};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_prog(input logic [7:0] a, input logic [7:0] d);
    prog_addr = a; prog_data = d; prog_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0;
  endtask

  task automatic do_erase(input logic [NS-1:0] m);
    erase_sel = m; erase_go = 1'b1;
    @(negedge clk);
    erase_go = 1'b0;
  endtask

  task automatic do_susp();
    susp_go = 1'b1; @(negedge clk); susp_go = 1'b0;
  endtask

  task automatic do_resume();
    resume_go = 1'b1; @(negedge clk); resume_go = 1'b0;
  endtask

  task automatic do_abort();
    abort_go = 1'b1; @(negedge clk); abort_go = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    rst_n = 1'b0; prog_go = 0; erase_go = 0; susp_go = 0; resume_go = 0;
    abort_go = 0; rd_en = 0; prog_addr = '0; rd_addr = '0; prog_data = '0;
    erase_sel = '0; sect_prot = 8'h80;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset rd_data", rd_data, 8'h00);

    // program table
    for (int i = 0; i < 6; i++) begin
      logic [7:0] pa, pd, st;
      pa = PVEC[i][15:8]; pd = PVEC[i][7:0];
      st = {~pd[7], 7'b000_0100};
      do_prog(pa, pd);
      rd(pa, a);
      rd(pa, b);
      if (i == 0) chk("R12 first DQ6", {7'b0, a[6]}, 8'h00);
      chk("R1 program status", a & 8'hBF, st);
      chk("R3 DQ6 inverts", {7'b0, b[6]}, {7'b0, ~a[6]});
      wait_cyc(5);
      rd(pa, a);
      chk("R1 still busy", a & 8'hBF, st);
      wait_cyc(6);
      rd(pa, a);
      chk("R2 data after program", a, pa ^ 8'h5A);
    end

    // R9 protected program
    do_prog(8'hE0, 8'h11);
    rd(8'hE0, a);
    chk("R9 protected program busy", a & 8'hBF, 8'h84);
    wait_cyc(6);
    rd(8'hE0, a);
    chk("R9 protected program back", a, 8'hE0 ^ 8'h5A);

    // erase of sectors 1 and 2
    do_erase(8'h06);
    rd(8'h20, a);
    chk("R4 window DQ3=0", a & 8'hBB, 8'h00);
    wait_cyc(8);
    rd(8'h24, a);
    rd(8'h24, b);
    chk("R4 erase started DQ3=1", a & 8'hBB, 8'h08);
    chk("R5 DQ2 toggles on erasing sector", {7'b0, b[2]}, {7'b0, ~a[2]});
    chk("R3 DQ6 inverts in erase", {7'b0, b[6]}, {7'b0, ~a[6]});
    rd(8'h80, a);
    rd(8'h80, b);
    chk("R5 DQ2 holds on other sector", {7'b0, b[2]}, {7'b0, a[2]});
    wait_cyc(25);
    rd(8'h24, a);
    chk("R10 no timeout within limit", a & 8'hBB, 8'h08);
    wait_cyc(10);
    rd(8'h24, a);
    chk("R2 data after erase", a, 8'h24 ^ 8'h5A);

    // erase suspend on sector 3
    do_erase(8'h08);
    wait_cyc(8);
    do_susp();
    rd(8'h64, a);
    rd(8'h64, b);
    chk("R6 suspended sector pattern", a & 8'hFB, 8'hC0);
    chk("R6 DQ2 toggles while suspended", {7'b0, b[2]}, {7'b0, ~a[2]});
    chk("R6 DQ6 constant", {7'b0, b[6]}, 8'h01);
    rd(8'h10, a);
    chk("R6 other sector data", a, 8'h10 ^ 8'h5A);
    do_prog(8'h12, 8'h80);
    rd(8'h12, a);
    rd(8'h12, b);
    chk("R7 program in suspend status", a & 8'hBF, 8'h04);
    chk("R7 DQ6 inverts", {7'b0, b[6]}, {7'b0, ~a[6]});
    wait_cyc(14);
    rd(8'h12, a);
    chk("R7 back to suspend data", a, 8'h12 ^ 8'h5A);
    do_prog(8'h66, 8'h00);
    rd(8'h12, a);
    chk("R7 program to erasing sector ignored", a, 8'h12 ^ 8'h5A);
    rd(8'h66, a);
    chk("R7 still erase suspended", a & 8'hFB, 8'hC0);
    do_resume();
    rd(8'h66, a);
    chk("R6 resume erase status", a & 8'hBB, 8'h08);
    wait_cyc(25);
    rd(8'h66, a);
    chk("R2 data after resumed erase", a, 8'h66 ^ 8'h5A);

    // program suspend
    do_prog(8'h40, 8'h3C);
    rd(8'h40, a);
    chk("R8 program status", a & 8'hBF, 8'h84);
    do_susp();
    rd(8'h40, a);
    chk("R8 suspended sector data", a, 8'h40 ^ 8'h5A);
    rd(8'hA0, a);
    chk("R8 other sector data", a, 8'hA0 ^ 8'h5A);
    do_resume();
    rd(8'h40, a);
    chk("R8 resumed status", a & 8'hBF, 8'h84);
    wait_cyc(15);
    rd(8'h40, a);
    chk("R8 data after program", a, 8'h40 ^ 8'h5A);

    // R9 fully protected erase
    do_erase(8'h80);
    rd(8'h00, a);
    chk("R9 protected erase busy", a & 8'hBB, 8'h00);
    wait_cyc(18);
    rd(8'h00, a);
    chk("R9 protected erase still busy", a & 8'hBB, 8'h00);
    wait_cyc(14);
    rd(8'h00, a);
    chk("R9 protected erase back", a, 8'h5A);

    // R10 timeout: three sectors exceed the limit
    do_erase(8'h07);
    wait_cyc(60);
    rd(8'h04, a);
    rd(8'h04, b);
    chk("R10 timeout flags", a & 8'hBB, 8'h28);
    chk("R10 DQ6 still toggles", {7'b0, b[6]}, {7'b0, ~a[6]});
    do_erase(8'h01);
    wait_cyc(100);
    rd(8'h04, a);
    chk("R10 timeout persists", a & 8'hBB, 8'h28);
    do_abort();
    rd(8'h04, a);
    chk("R10 abort returns to read", a, 8'h04 ^ 8'h5A);

    // R11 events while busy ignored
    do_prog(8'h20, 8'h00);
    do_erase(8'h02);
    do_abort();
    rd(8'h20, a);
    chk("R11 abort ignored while programming", a & 8'hBF, 8'h84);
    wait_cyc(14);
    rd(8'h20, a);
    chk("R11 erase during program ignored", a, 8'h20 ^ 8'h5A);
    rd_addr = 8'h33;
    wait_cyc(3);
    chk("R2 rd_data holds without read", rd_data, 8'h20 ^ 8'h5A);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule